// File: doc/BRIEF.md
# Boot ROM and SRAM Remap Window

This block serves a 128 KiB address window that is split into four 32 KiB quarters. Each quarter is steered to one of four sources: the two halves of a 64 KiB SRAM bank (A1 and A2), a 32 KiB SRAM bank B, an 8 KiB read-only boot ROM repeated as many times as needed to fill the space it covers, or an empty hole. The choice depends on two bits in a small control register (a remap bit and a ROM-disable bit) and on which of two aliases of the window the request uses. The low alias is the window's place in the peripheral area. The high alias is the window's copy at the top of the address space.

Early boot code runs from the ROM through the high alias and copies the next stage into SRAM. Later stages set the remap bit, which moves bank A into the upper half of the window. Finally they disable the ROM, so that both aliases show SRAM only. Requests are single-cycle and synchronous. Read data is registered and comes back one cycle after the request. The SRAM depth per quarter is a parameter, so simulation can use small arrays. The ROM contents are computed at elaboration from a seed parameter.

Top module: `romsram_window`

## Requirements
- R1: After reset, the control register holds remap = 0 and ROM-disable = 0 (ROM enabled), and `rdValid` is 0.
- R2: With ROM-disable = 1 and remap = 0, the quarters (selected by `reqOffset[16:15]` = 0, 1, 2, 3) map to A1, A2, B and the hole on both aliases.
- R3: With ROM-disable = 1 and remap = 1, the quarters map to B, the hole, A1 and A2 on both aliases.
- R4: With ROM enabled and remap = 0, the low alias (`reqAlias` = 0) maps A1, A2, B and the hole. The high alias (`reqAlias` = 1) maps A1 and A2 to quarters 0 and 1 and the ROM to quarters 2 and 3.
- R5: With ROM enabled and remap = 1, the low alias maps the ROM to all four quarters. The high alias maps the ROM to quarters 0 and 1, A1 to quarter 2 and A2 to quarter 3.
- R6: A ROM read returns `ROM_SEED ^ (i * 32'h9E3779B9)`, truncated to 32 bits, where i = `reqOffset[12:2]`. The ROM therefore repeats every 8 KiB.
- R7: Writes to a ROM or hole location change no stored word. Reads from the hole return 0.
- R8: An SRAM write updates only the byte lanes whose `reqStrb` bit is set. Bit k covers `reqWdata[8k+7:8k]`.
- R9: A read (`reqValid` = 1, `reqWrite` = 0) gives `rdData` and `rdValid` = 1 on the next cycle. A write or an idle cycle gives `rdValid` = 0 on the next cycle.
- R10: When `cfgWe` is 1 at a clock edge, the register loads `cfgRemap` and `cfgRomOff`. `ctrlRemap` and `ctrlRomOff` show the loaded values from the next cycle on. The new decode applies from the next request on.
- R11: Within a quarter, SRAM uses word index `reqOffset[SRAM_QW_BITS+1:2]`. Higher offset bits inside the quarter select the same word. Bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAlias | input | 1 | 0 = low alias, 1 = high alias |
| reqOffset | input | 17 | Byte offset inside the window |
| reqWdata | input | 32 | Write data |
| reqStrb | input | 4 | Byte-lane write enables |
| cfgWe | input | 1 | Load the control register |
| cfgRemap | input | 1 | Remap value to load |
| cfgRomOff | input | 1 | ROM-disable value to load |
| rdData | output | 32 | Read data, one cycle after the request |
| rdValid | output | 1 | Read data valid |
| ctrlRemap | output | 1 | Current remap bit |
| ctrlRomOff | output | 1 | Current ROM-disable bit |

## Verification
The assertions assume the following about the inputs:
- All request and configuration inputs are known (not X) at every clock edge after reset.
- `reqWrite` and `reqStrb` have meaning only while `reqValid` is high.
- A configuration write in the same cycle as a request does not change how that request is decoded.

The stimulus drives every input to a defined value on the falling edge. It drops `reqValid` between accesses and changes configuration only in its own cycles. Random offsets range over the full quarter, so SRAM word folding and ROM mirroring are both exercised.

// File: rtl/romsram_pkg.sv
package romsram_pkg;

  typedef enum logic [2:0] {
    SRC_A1   = 3'd0,
    SRC_A2   = 3'd1,
    SRC_B    = 3'd2,
    SRC_ROM  = 3'd3,
    SRC_HOLE = 3'd4
  } srcSel_e;

  typedef struct packed {
    logic    rdEn;
    logic    wrA;
    logic    wrB;
    logic    aHigh;
    srcSel_e src;
  } dpStrobe_t;

  // ROM contents derived from a seed and the word index
  function automatic logic [31:0] romWord(input logic [31:0] seed, input logic [31:0] idx);
    logic [31:0] prod;
    prod = idx * 32'h9E3779B9;
    return seed ^ prod;
  endfunction

  // Quarter-to-source decode for a given control setting and alias
  function automatic srcSel_e quarterSource(input logic remap, input logic romOff,
                                            input logic highAlias, input logic [1:0] q);
    srcSel_e s;
    if (romOff || (!remap && !highAlias)) begin
      // plain layouts, identical on both aliases once the ROM is gone
      if (!remap) begin
        case (q)
          2'd0: s = SRC_A1;
          2'd1: s = SRC_A2;
          2'd2: s = SRC_B;
          default: s = SRC_HOLE;
        endcase
      end else begin
        case (q)
          2'd0: s = SRC_B;
          2'd1: s = SRC_HOLE;
          2'd2: s = SRC_A1;
          default: s = SRC_A2;
        endcase
      end
    end else if (!remap) begin
      // ROM enabled, high alias: A in lower half, ROM above
      s = q[1] ? SRC_ROM : (q[0] ? SRC_A2 : SRC_A1);
    end else if (!highAlias) begin
      s = SRC_ROM;
    end else begin
      s = q[1] ? (q[0] ? SRC_A2 : SRC_A1) : SRC_ROM;
    end
    return s;
  endfunction

endpackage

// File: rtl/romsram_ctrl.sv
module romsram_ctrl
  import romsram_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       reqAlias,
  input  logic [1:0] reqQuarter,
  input  logic       cfgWe,
  input  logic       cfgRemap,
  input  logic       cfgRomOff,
  output dpStrobe_t  stb,
  output logic       remapQ,
  output logic       romOffQ
);

  srcSel_e srcNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remapQ  <= 1'b0;
      romOffQ <= 1'b0;
    end else if (cfgWe) begin
      remapQ  <= cfgRemap;
      romOffQ <= cfgRomOff;
    end
  end

  always_comb begin
    srcNow    = quarterSource(remapQ, romOffQ, reqAlias, reqQuarter);
    stb.src   = srcNow;
    stb.rdEn  = reqValid && !reqWrite;
    stb.wrA   = reqValid && reqWrite && ((srcNow == SRC_A1) || (srcNow == SRC_A2));
    stb.wrB   = reqValid && reqWrite && (srcNow == SRC_B);
    stb.aHigh = (srcNow == SRC_A2);
  end

  // R1: reset state of the control register
  a_r1_reset_state: assert property (@(posedge clk) !rstN |=> (!remapQ && !romOffQ));

  // R10: a configuration write loads both bits
  a_r10_cfg_load: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> (remapQ == $past(cfgRemap)) && (romOffQ == $past(cfgRomOff)));

  // R10: without a configuration write the bits hold
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWe |=> $stable(remapQ) && $stable(romOffQ));

  // R5 / R7: the low alias with ROM enabled and remap set never writes SRAM
  a_r7_rom_no_write: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && !romOffQ && remapQ && !reqAlias) |-> !(stb.wrA || stb.wrB));

endmodule

// File: rtl/romsram_dp.sv
module romsram_dp
  import romsram_pkg::*;
#(
  parameter int          SRAM_QW_BITS  = 8,
  parameter int          ROM_WORD_BITS = 11,
  parameter logic [31:0] ROM_SEED      = 32'hC0DE5EED
) (
  input  logic        clk,
  input  logic        rstN,
  input  dpStrobe_t   stb,
  input  logic [12:0] wordIdx,
  input  logic [31:0] wdata,
  input  logic [3:0]  strb,
  output logic [31:0] rdData,
  output logic        rdValid
);

  localparam int A_DEPTH = 2 ** (SRAM_QW_BITS + 1);
  localparam int B_DEPTH = 2 ** SRAM_QW_BITS;
  localparam int LANES   = 4;

  logic [SRAM_QW_BITS:0]   aIdx;
  logic [SRAM_QW_BITS-1:0] bIdx;
  logic [31:0]             aWord, bWord, romData, nextData;
  logic                    unusedIdxBits;

  assign bIdx          = wordIdx[SRAM_QW_BITS-1:0];
  assign aIdx          = {stb.aHigh, bIdx};
  assign romData       = romWord(ROM_SEED, 32'(wordIdx[ROM_WORD_BITS-1:0]));
  assign unusedIdxBits = ^wordIdx;

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic [7:0] memA [A_DEPTH];
    logic [7:0] memB [B_DEPTH];

    always_ff @(posedge clk) begin
      if (stb.wrA && strb[lane]) memA[aIdx] <= wdata[lane*8 +: 8];
      if (stb.wrB && strb[lane]) memB[bIdx] <= wdata[lane*8 +: 8];
    end

    assign aWord[lane*8 +: 8] = memA[aIdx];
    assign bWord[lane*8 +: 8] = memB[bIdx];
  end

  always_comb begin
    case (stb.src)
      SRC_A1, SRC_A2: nextData = aWord;
      SRC_B:          nextData = bWord;
      SRC_ROM:        nextData = romData;
      default:        nextData = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.rdEn;
      if (stb.rdEn) rdData <= nextData;
    end
  end

  // R9: a read returns data on the next cycle
  a_r9_read_valid: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdEn |=> rdValid);

  // R9: no valid data after a write or an idle cycle
  a_r9_no_valid: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdEn |=> !rdValid);

  // R7: reads of the hole return zero
  a_r7_hole_zero: assert property (@(posedge clk) disable iff (!rstN)
    (stb.rdEn && stb.src == SRC_HOLE) |=> (rdData == '0));

  // R8: at most one bank is written per cycle
  a_r8_one_bank: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.wrA, stb.wrB}));

endmodule

// File: rtl/romsram_window.sv
module romsram_window
  import romsram_pkg::*;
#(
  parameter int          SRAM_QW_BITS  = 8,
  parameter int          ROM_WORD_BITS = 11,
  parameter logic [31:0] ROM_SEED      = 32'hC0DE5EED
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        reqWrite,
  input  logic        reqAlias,
  input  logic [16:0] reqOffset,
  input  logic [31:0] reqWdata,
  input  logic [3:0]  reqStrb,
  input  logic        cfgWe,
  input  logic        cfgRemap,
  input  logic        cfgRomOff,
  output logic [31:0] rdData,
  output logic        rdValid,
  output logic        ctrlRemap,
  output logic        ctrlRomOff
);

  dpStrobe_t stb;
  logic      unusedByteBits;

  assign unusedByteBits = ^reqOffset[1:0];

  romsram_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqWrite   (reqWrite),
    .reqAlias   (reqAlias),
    .reqQuarter (reqOffset[16:15]),
    .cfgWe      (cfgWe),
    .cfgRemap   (cfgRemap),
    .cfgRomOff  (cfgRomOff),
    .stb        (stb),
    .remapQ     (ctrlRemap),
    .romOffQ    (ctrlRomOff)
  );

  romsram_dp #(
    .SRAM_QW_BITS  (SRAM_QW_BITS),
    .ROM_WORD_BITS (ROM_WORD_BITS),
    .ROM_SEED      (ROM_SEED)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wordIdx (reqOffset[14:2]),
    .wdata   (reqWdata),
    .strb    (reqStrb),
    .rdData  (rdData),
    .rdValid (rdValid)
  );

endmodule

// File: tb/sim_romsram_window.sv
module sim_romsram_window;

  localparam int          QW   = 8;
  localparam logic [31:0] SEED = 32'hC0DE5EED;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqAlias = 1'b0;
  logic [16:0] reqOffset = '0;
  logic [31:0] reqWdata = '0;
  logic [3:0]  reqStrb = '0;
  logic        cfgWe = 1'b0, cfgRemap = 1'b0, cfgRomOff = 1'b0;
  logic [31:0] rdData;
  logic        rdValid, ctrlRemap, ctrlRomOff;

  int nChecks = 0, nFails = 0;
  bit done = 0;
  bit mRemap = 0, mRomOff = 0;
  logic [31:0] mA [2*(2**QW)];
  logic [31:0] mB [2**QW];

  always #2.5 clk = ~clk;

  romsram_window u0 (.*);

  // 0 A1, 1 A2, 2 B, 3 ROM, 4 hole
  function automatic int expSrc(bit rOff, bit rmp, bit hi, int q);
    if (rOff) return rmp ? (q == 0 ? 2 : q == 1 ? 4 : q == 2 ? 0 : 1)
                         : (q == 3 ? 4 : q);
    if (!rmp) return hi ? (q < 2 ? q : 3) : (q == 3 ? 4 : q);
    return hi ? (q < 2 ? 3 : q - 2) : 3;
  endfunction

  function automatic logic [31:0] expRom(logic [16:0] off);
    logic [31:0] i;
    i = 32'(off[12:2]);
    return SEED ^ (i * 32'h9E3779B9);
  endfunction

  function automatic logic [31:0] expRead(bit hi, logic [16:0] off);
    int s, w;
    s = expSrc(mRomOff, mRemap, hi, int'(off[16:15]));
    w = int'(off[QW+1:2]);
    case (s)
      0: return mA[w];
      1: return mA[w + 2**QW];
      2: return mB[w];
      3: return expRom(off);
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setCfg(bit rmp, bit rOff);
    @(negedge clk);
    cfgWe = 1; cfgRemap = rmp; cfgRomOff = rOff;
    @(negedge clk);
    cfgWe = 0;
    mRemap = rmp; mRomOff = rOff;
    check("R10", {30'b0, ctrlRemap, ctrlRomOff}, {30'b0, rmp, rOff});
  endtask

  task automatic doWrite(bit hi, logic [16:0] off, logic [31:0] d, logic [3:0] st);
    int s, w;
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAlias = hi; reqOffset = off; reqWdata = d; reqStrb = st;
    @(negedge clk);
    reqValid = 0; reqWrite = 0;
    check("R9", {31'b0, rdValid}, 32'h0);
    s = expSrc(mRomOff, mRemap, hi, int'(off[16:15]));
    w = int'(off[QW+1:2]);
    if (s == 1) w += 2**QW;
    for (int k = 0; k < 4; k++) begin
      if (st[k] && (s == 0 || s == 1)) mA[w][k*8 +: 8] = d[k*8 +: 8];
      if (st[k] && s == 2)             mB[w][k*8 +: 8] = d[k*8 +: 8];
    end
  endtask

  task automatic doRead(string req, bit hi, logic [16:0] off);
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqAlias = hi; reqOffset = off;
    @(negedge clk);
    reqValid = 0;
    check("R9", {31'b0, rdValid}, 32'h1);
    check(req, rdData, expRead(hi, off));
  endtask

  function automatic string mapReq(bit rOff, bit rmp);
    if (rOff) return rmp ? "R3" : "R2";
    return rmp ? "R5" : "R4";
  endfunction

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1", {30'b0, ctrlRemap, ctrlRomOff}, 32'h0);
    check("R1", {31'b0, rdValid}, 32'h0);
    rstN = 1;
    @(negedge clk);

    // fill A and B with distinct patterns through the plain layout
    setCfg(0, 1);
    for (int w = 0; w < 2**QW; w++) begin
      doWrite(0, 17'(w * 4),            32'hA1000000 | w, 4'hF);
      doWrite(0, 17'(32'h8000 + w * 4), 32'hA2000000 | w, 4'hF);
      doWrite(0, 17'(32'h10000 + w * 4), 32'hB0000000 | w, 4'hF);
    end

    // every quarter under all control settings and both aliases
    for (int c = 0; c < 4; c++) begin
      setCfg(c[0], c[1]);
      for (int hi = 0; hi < 2; hi++)
        for (int q = 0; q < 4; q++)
          for (int j = 0; j < 3; j++)
            doRead(mapReq(c[1], c[0]), hi[0], 17'(q * 32'h8000 + j * 36 + 4));
    end

    // R6: ROM mirroring, same word at two mirrors
    setCfg(1, 0);
    doRead("R6", 0, 17'h00010);
    doRead("R6", 0, 17'h12010);
    doRead("R6", 1, 17'h06010);
    // R7: writes to ROM and hole ignored, hole reads zero
    doWrite(0, 17'h00010, 32'hDEADBEEF, 4'hF);
    doRead("R7", 0, 17'h00010);
    setCfg(0, 1);
    doWrite(1, 17'h18020, 32'h12345678, 4'hF);
    doRead("R7", 1, 17'h18020);
    doRead("R7", 0, 17'h10020);
    // R8: partial strobes
    doWrite(0, 17'h00040, 32'h11223344, 4'b0101);
    doRead("R8", 0, 17'h00040);
    doWrite(1, 17'h10044, 32'h55667788, 4'b1010);
    doRead("R8", 1, 17'h10044);
    // R11: folding and ignored byte bits
    doRead("R11", 0, 17'(32'h00040 + (4 << QW)));
    doRead("R11", 0, 17'h00043);

    // random mix
    for (int n = 0; n < 1500; n++) begin
      logic [16:0] off;
      if (n % 40 == 0) setCfg($urandom % 2 == 1, $urandom % 2 == 1);
      off = 17'($urandom);
      if ($urandom % 3 == 0)
        doWrite($urandom % 2 == 1, off, $urandom, 4'($urandom));
      else
        doRead(mapReq(mRomOff, mRemap), $urandom % 2 == 1, off);
    end

    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule